// File: doc/BRIEF.md
# Nine-Bit Programmable Feedback Divider

This block sits in the feedback path of a frequency synthesizer. It is clocked by the oscillator-derived signal that is to be divided. It counts that clock down by a ratio N set on a 9-bit binary program word, and it emits one single-cycle pulse every N input cycles. A phase comparator elsewhere consumes that pulse. The program word is read only when the counter wraps, so a new ratio never shortens a period that is already under way.

Two program values are folded away from a plain binary count. Code 0 divides by 2 and code 1 divides by 3, which keeps the smallest ratio at 2. The program word and the output are plain control pins with no handshake: the pulse is a strobe and cannot be back-pressured. A program pin left undriven at board level should be tied low, so that it reads as 0.

Top module: `fb_divider`

## Requirements
- R1: For a program code from 2 to 511 (bit 0 is the least significant bit), the output pulses exactly once every code-value clock cycles.
- R2: Program code 0 divides by 2.
- R3: Program code 1 divides by 3.
- R4: Each output pulse is high for exactly one clock cycle and is followed by at least one low cycle.
- R5: The program word is sampled only on the clock edge where the counter wraps (the edge that raises the pulse). A change made at any other time takes effect from the following period, and the running period keeps its old length.
- R6: While the synchronous active-high reset is applied the output is low from the first reset edge onward. After release, the first pulse comes exactly N edges later, where N is the ratio of the code held during reset.
- R7: The largest code, 511, divides by 511.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Clock to be divided (oscillator-derived) |
| rst | input | 1 | Synchronous active-high reset |
| code_in | input | 9 | Binary program word selecting the divide ratio |
| pulse_out | output | 1 | One-cycle strobe, once per N input cycles |

## Verification
A pulse is due N rising edges after the edge that raised the previous pulse. The first pulse after reset is due N edges after the first edge with reset low. The value of N is whatever code sat on the program pins at the wrap edge. The bench changes the code only at falling edges, so the code is stable at every rising edge. One nanosecond after each wrap edge, the driver queues the ratio that the requirements give for the code present at that edge. The monitor measures the edge distance between pulses at falling edges and compares it with the queued entries in order, so each period is judged against the code captured at its own start.

// File: rtl/fb_div_pkg.sv
package fb_div_pkg;
  // Smallest divide ratio; codes below it are folded upward.
  localparam int unsigned MIN_RATIO = 2;

  // Maps a program code to its divide ratio.
  function automatic logic [8:0] fold_code(input logic [8:0] code);
    if (code < 9'(MIN_RATIO)) return code + 9'(MIN_RATIO);
    return code;
  endfunction
endpackage

// File: rtl/fb_div_ratio_map.sv
module fb_div_ratio_map
  import fb_div_pkg::*;
#(
  parameter int unsigned CODE_W = 9
) (
  input  logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] ratio
);
  localparam logic [CODE_W-1:0] LOW_LIMIT = CODE_W'(MIN_RATIO);

  // Codes below the floor fold up by the floor; others pass through.
  always_comb begin
    if (code < LOW_LIMIT) ratio = code + LOW_LIMIT;
    else                  ratio = code;
  end
endmodule

// File: rtl/fb_div_counter.sv
module fb_div_counter #(
  parameter int unsigned CODE_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] preset,
  output logic [CODE_W-1:0] count,
  output logic              at_end
);
  assign at_end = (count == '0);

  // Reload on reset or wrap, otherwise step down by one.
  always_ff @(posedge clk) begin
    if (rst || at_end) count <= preset;
    else               count <= count - 1'b1;
  end
endmodule

// File: rtl/fb_div_strobe.sv
module fb_div_strobe (
  input  logic clk,
  input  logic rst,
  input  logic wrap,
  output logic strobe
);
  always_ff @(posedge clk) begin
    if (rst) strobe <= 1'b0;
    else     strobe <= wrap;
  end
endmodule

// File: rtl/fb_divider.sv
module fb_divider #(
  parameter int unsigned CODE_W = 9
) (
  input  logic              clk_in,
  input  logic              rst,
  input  logic [CODE_W-1:0] code_in,
  output logic              pulse_out
);
  logic [CODE_W-1:0] ratio;
  logic [CODE_W-1:0] preset;
  logic [CODE_W-1:0] count;
  logic              at_end;

  fb_div_ratio_map #(.CODE_W(CODE_W)) u_map (
    .code  (code_in),
    .ratio (ratio)
  );

  assign preset = ratio - 1'b1;

  fb_div_counter #(.CODE_W(CODE_W)) u_cnt (
    .clk    (clk_in),
    .rst    (rst),
    .preset (preset),
    .count  (count),
    .at_end (at_end)
  );

  fb_div_strobe u_strobe (
    .clk    (clk_in),
    .rst    (rst),
    .wrap   (at_end),
    .strobe (pulse_out)
  );

  // R4
  pulse_width_chk: assert property (@(posedge clk_in) disable iff (rst)
    pulse_out |=> !pulse_out);

  // R6
  rst_quiet_chk: assert property (@(posedge clk_in)
    rst |=> !pulse_out);

  // R5
  count_step_chk: assert property (@(posedge clk_in) disable iff (rst)
    (!$past(rst) && !$past(at_end)) |-> (count == $past(count) - 1'b1));

  // R1
  reload_chk: assert property (@(posedge clk_in) disable iff (rst)
    (!$past(rst) && $past(at_end)) |-> (count == $past(ratio) - 1'b1));

  // R2
  ratio_min_chk: assert property (@(posedge clk_in) disable iff (rst)
    ratio >= CODE_W'(2));
endmodule

// File: tb/fb_divider_test.sv
`timescale 1ns/1ps
module fb_divider_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [8:0] code = 9'd5;
  logic       pulse;

  int checks = 0;
  int fails  = 0;
  int edge_cnt = 0;
  int rst_edges = 0;
  int last_pulse = 0;
  logic prev_pulse = 1'b0;
  int prev_code = -1;
  bit done = 0;

  int    exp_len[$];
  string exp_tag[$];

  fb_divider uut (.clk_in(clk), .rst(rst), .code_in(code), .pulse_out(pulse));

  always #2.5 clk = ~clk;

  function automatic int ratio_of(input int c);
    return (c < 2) ? c + 2 : c;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Edge counter since reset release.
  always @(posedge clk) begin
    if (rst) begin edge_cnt <= 0; rst_edges <= rst_edges + 1; end
    else begin edge_cnt <= edge_cnt + 1; rst_edges <= 0; end
  end

  // Driver side: at each wrap edge, queue the period the current code implies.
  always @(posedge clk) begin
    #1;
    if (!rst && pulse) begin
      string t;
      if (int'(code) != prev_code) t = "R5";
      else if (code == 9'd0) t = "R2";
      else if (code == 9'd1) t = "R3";
      else if (code == 9'd511) t = "R7";
      else t = "R1";
      exp_len.push_back(ratio_of(int'(code)));
      exp_tag.push_back(t);
      prev_code = int'(code);
    end
  end

  // Monitor: measure pulse spacing and compare with the queue.
  always @(negedge clk) begin
    if (rst) begin
      last_pulse = 0;
      if (rst_edges >= 1) check(pulse == 1'b0, "R6", int'(pulse), 0);
      prev_pulse = 1'b0;
    end else begin
      if (pulse) begin
        int gap;
        check(prev_pulse == 1'b0, "R4", int'(prev_pulse), 0);
        gap = edge_cnt - last_pulse;
        last_pulse = edge_cnt;
        if (exp_len.size() == 0) begin
          check(1'b0, "R1", gap, -1);
        end else begin
          int e;
          string t;
          e = exp_len.pop_front();
          t = exp_tag.pop_front();
          check(gap == e, t, gap, e);
        end
      end
      prev_pulse = pulse;
    end
  end

  task automatic apply_reset(input int c);
    @(posedge clk);
    #2;
    rst = 1'b1;
    code = 9'(c);
    repeat (4) @(posedge clk);
    #2;
    exp_len.delete();
    exp_tag.delete();
    exp_len.push_back(ratio_of(c));
    exp_tag.push_back("R6");
    prev_code = c;
    rst = 1'b0;
  endtask

  task automatic wait_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!pulse);
    end
  endtask

  task automatic set_code(input int c);
    @(negedge clk);
    code = 9'(c);
  endtask

  initial begin
    apply_reset(5);
    wait_pulses(4);
    set_code(0);   wait_pulses(5);   // R2
    set_code(1);   wait_pulses(5);   // R3
    set_code(2);   wait_pulses(5);   // R1 smallest plain code
    set_code(7);   wait_pulses(4);   // R1
    set_code(511); wait_pulses(4);   // R7
    set_code(300); wait_pulses(3);   // R1
    // R5: change in the middle of a long period
    wait_pulses(1);
    repeat (100) @(negedge clk);
    code = 9'd9;
    wait_pulses(4);
    // R5: only the value present at the wrap edge counts
    repeat (3) @(negedge clk);
    code = 9'd6;
    repeat (2) @(negedge clk);
    code = 9'd4;
    wait_pulses(5);
    // R6: reset in mid-run with a new code
    repeat (2) @(negedge clk);
    apply_reset(3);
    wait_pulses(4);
    apply_reset(0);
    wait_pulses(3);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule